// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Timer

This block is an up-counting timer for pulse-width modulation. A shared clock divider slows the count rate, and a shared reload limit sets the length of one cycle. Up to four compare channels each produce a main PWM output and a complementary output. Every channel has its own compare threshold and its own enable and polarity bits, and the complementary output has a separate enable and polarity bit too.

Software programs the block through a single-cycle register write port. A preload mode lets new divider, reload and compare values wait until the next update event. An update event happens when the counter wraps, or when software requests one through a self-clearing control bit. The outputs drive only while both the counter run bit and the master output gate are set.

Top module: `multich_pwm_timer`

## Requirements
- R1: The counter advances once every (P+1) clocks and counts 0..A, so one output period lasts (P+1)*(A+1) clocks, where P is the divider value and A is the reload value.
- R2: With polarity clear, a channel's main output is high while the counter is below its compare value C, so the output is high for C*(P+1) clocks per period. A compare value of 0 keeps the output low.
- R3: A compare value greater than A keeps the main output high for the whole period.
- R4: Setting the channel polarity bit inverts the output. The output is then high for ((A+1)-C)*(P+1) clocks at the end of each period.
- R5: When its own enable bit is set, the complementary output is the inverse of the un-inverted compare result, XORed with its own polarity bit. When that enable bit is clear, the complementary output stays low.
- R6: When a channel's enable bit is clear, both of its outputs stay low, whatever its complementary enable bit holds.
- R7: When the run bit or the master output gate is clear, every output stays low. With run clear, the counter holds its value.
- R8: With preload set, writes to the divider, reload and compare registers change nothing until the next update event. An update event is a counter wrap from A to 0, or a software update request.
- R9: With preload clear, a written value takes effect in the output at most two clocks after the write.
- R10: A software update request restarts the counter and the divider at 0 and loads the preloaded values.
- R11: Register map, selected by `wr_addr`:
  - Address 0 is control: bit0 run, bit1 preload, bit2 master output gate. Bit3 requests an update and is not stored.
  - Address 1 is the divider and address 2 is the reload value.
  - Address 3 holds the channel configuration, four bits per channel at [4k+3:4k]: bit0 enable, bit1 polarity, bit2 complementary enable, bit3 complementary polarity.
  - Address 4+k is the compare value of channel k.
- R12: After reset all registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| pwm_out | output | NCH | Main PWM output per channel |
| pwm_n_out | output | NCH | Complementary PWM output per channel |

## Verification
A table of settings drives channel 0 with different divider, reload and compare combinations, and the bench counts high clocks over one exact period. Mid-range compare values separate the period formula from the duty formula. Compare values of zero and above the reload value expose off-by-one errors at both ends. Polarity and complementary settings show whether the inversion is applied on the correct path. Directed sequences write compare values mid-period with preload on and with preload off, to show when a value takes effect, and a two-channel run shows that the channels stay independent.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int REG_CTRL  = 0;
    localparam int REG_DIV   = 1;
    localparam int REG_LIMIT = 2;
    localparam int REG_CHCFG = 3;
    localparam int REG_CMP0  = 4;

    localparam int CFG_BITS  = 4;
    localparam int CTRL_UPD_BIT = 3;

    typedef struct packed {
        logic moe;
        logic preload;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic cpol;
        logic cen;
        logic pol;
        logic en;
    } chan_cfg_t;

    function automatic logic chan_main(input chan_cfg_t c, input logic ref_hi, input logic gate);
        return gate & c.en & (ref_hi ^ c.pol);
    endfunction

    function automatic logic chan_comp(input chan_cfg_t c, input logic ref_hi, input logic gate);
        return gate & c.en & c.cen & (~ref_hi ^ c.cpol);
    endfunction

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output ctrl_t                      ctrl,
    output logic                       upd_req,
    output logic [CNT_W-1:0]           div_pre,
    output logic [CNT_W-1:0]           lim_pre,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_pre,
    output logic [NCH*CFG_BITS-1:0]    ch_cfg
);
    localparam int CFG_W = NCH * CFG_BITS;

    logic sel_ctrl, sel_div, sel_lim, sel_cfg;

    assign sel_ctrl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign sel_div  = wr_en && (wr_addr == ADDR_W'(REG_DIV));
    assign sel_lim  = wr_en && (wr_addr == ADDR_W'(REG_LIMIT));
    assign sel_cfg  = wr_en && (wr_addr == ADDR_W'(REG_CHCFG));

    assign upd_req  = sel_ctrl && wr_data[CTRL_UPD_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div_pre <= '0;
            lim_pre <= '0;
            ch_cfg  <= '0;
        end else begin
            if (sel_ctrl) ctrl    <= ctrl_t'(wr_data[2:0]);
            if (sel_div)  div_pre <= wr_data[CNT_W-1:0];
            if (sel_lim)  lim_pre <= wr_data[CNT_W-1:0];
            if (sel_cfg)  ch_cfg  <= wr_data[CFG_W-1:0];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_pre[k] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(REG_CMP0 + k))) begin
                cmp_pre[k] <= wr_data[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       preload,
    input  logic                       uev,
    input  logic [CNT_W-1:0]           div_pre,
    input  logic [CNT_W-1:0]           lim_pre,
    input  logic [NCH-1:0][CNT_W-1:0]  cmp_pre,
    output logic [CNT_W-1:0]           div_eff,
    output logic [CNT_W-1:0]           lim_eff,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_eff
);
    logic [CNT_W-1:0]          div_sh, lim_sh;
    logic [NCH-1:0][CNT_W-1:0] cmp_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_sh <= '0;
            lim_sh <= '0;
            cmp_sh <= '0;
        end else if (uev) begin
            div_sh <= div_pre;
            lim_sh <= lim_pre;
            cmp_sh <= cmp_pre;
        end
    end

    assign div_eff = preload ? div_sh : div_pre;
    assign lim_eff = preload ? lim_sh : lim_pre;
    assign cmp_eff = preload ? cmp_sh : cmp_pre;

endmodule

// File: rtl/pwm_time_base.sv
module pwm_time_base #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             upd_req,
    input  logic [CNT_W-1:0] div_eff,
    input  logic [CNT_W-1:0] lim_eff,
    output logic [CNT_W-1:0] cnt,
    output logic             uev
);
    logic [CNT_W-1:0] div_cnt;
    logic             tick, at_top;

    assign tick   = run && (div_cnt >= div_eff);
    assign at_top = cnt >= lim_eff;
    assign uev    = upd_req || (tick && at_top);

    always_ff @(posedge clk) begin
        if (rst || upd_req) begin
            div_cnt <= '0;
            cnt     <= '0;
        end else if (run) begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  chan_cfg_t        cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             out_main,
    output logic             out_comp
);
    logic ref_hi;

    assign ref_hi = cnt < cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_main <= 1'b0;
            out_comp <= 1'b0;
        end else begin
            out_main <= chan_main(cfg, ref_hi, gate);
            out_comp <= chan_comp(cfg, ref_hi, gate);
        end
    end

endmodule

// File: rtl/multich_pwm_timer.sv
module multich_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_n_out
);
    localparam int CFG_W = NCH * CFG_BITS;

    ctrl_t                     ctrl;
    logic                      upd_req, uev;
    logic                      run_en, out_gate;
    logic [CNT_W-1:0]          div_pre, lim_pre, div_eff, lim_eff, cnt_q;
    logic [NCH-1:0][CNT_W-1:0] cmp_pre, cmp_eff;
    logic [CFG_W-1:0]          ch_cfg;

    assign run_en   = ctrl.run;
    assign out_gate = ctrl.run & ctrl.moe;

    pwm_reg_bank #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .upd_req(upd_req), .div_pre(div_pre), .lim_pre(lim_pre),
        .cmp_pre(cmp_pre), .ch_cfg(ch_cfg)
    );

    pwm_shadow #(.CNT_W(CNT_W), .NCH(NCH)) u_shadow (
        .clk(clk), .rst(rst), .preload(ctrl.preload), .uev(uev),
        .div_pre(div_pre), .lim_pre(lim_pre), .cmp_pre(cmp_pre),
        .div_eff(div_eff), .lim_eff(lim_eff), .cmp_eff(cmp_eff)
    );

    pwm_time_base #(.CNT_W(CNT_W)) u_base (
        .clk(clk), .rst(rst), .run(run_en), .upd_req(upd_req),
        .div_eff(div_eff), .lim_eff(lim_eff), .cnt(cnt_q), .uev(uev)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        pwm_chan_out #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .gate(out_gate),
            .cfg(chan_cfg_t'(ch_cfg[k*CFG_BITS +: CFG_BITS])),
            .cnt(cnt_q), .cmp(cmp_eff[k]),
            .out_main(pwm_out[k]), .out_comp(pwm_n_out[k])
        );
    end

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               upd_req,
    input logic               run_en,
    input logic               out_gate,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [NCH*4-1:0]   ch_cfg,
    input logic [NCH-1:0]     pwm_out,
    input logic [NCH-1:0]     pwm_n_out
);
    // R10: an update request restarts the count
    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        upd_req |=> (cnt_q == '0));

    // R7: counter frozen while not running
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !upd_req) |=> $stable(cnt_q));

    // R7: outputs low when run or master gate is clear
    assert_gate_low_R7: assert property (@(posedge clk) disable iff (rst)
        !out_gate |=> (pwm_out == '0 && pwm_n_out == '0));

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        // R6: disabled channel drives nothing
        assert_disabled_low_R6: assert property (@(posedge clk) disable iff (rst)
            !ch_cfg[4*k] |=> (!pwm_out[k] && !pwm_n_out[k]));

        // R5: complementary relation to main output
        assert_comp_rel_R5: assert property (@(posedge clk) disable iff (rst)
            (out_gate && ch_cfg[4*k] && ch_cfg[4*k+2]) |=>
            (pwm_n_out[k] == (~pwm_out[k] ^ $past(ch_cfg[4*k+1]) ^ $past(ch_cfg[4*k+3]))));
    end

endmodule

bind multich_pwm_timer pwm_timer_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_checker (
    .clk(clk), .rst(rst), .upd_req(upd_req), .run_en(run_en), .out_gate(out_gate),
    .cnt_q(cnt_q), .ch_cfg(ch_cfg), .pwm_out(pwm_out), .pwm_n_out(pwm_n_out)
);

// File: tb/multich_pwm_timer_test.sv
module multich_pwm_timer_test;

    localparam int CNT_W = 16;
    localparam int NCH = 4;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    typedef struct packed {
        int psc; int lim; int cmp; int cfg; int hm; int hn; int per;
    } vec_t;

    // cfg nibble: bit0 en, bit1 pol, bit2 comp en, bit3 comp pol (R11)
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{0, 9, 3,  5,  3,  7, 10},  // R2 R5 R1 mid duty
        '{1, 4, 2,  1,  4,  0, 10},  // R1 R2 divider>0, comp disabled R5
        '{2, 3, 4,  5, 12,  0,  0},  // R3 compare = limit+1 -> full
        '{0, 9, 0,  5,  0, 10,  0},  // R2 compare 0 -> never high
        '{0, 9, 3,  3,  7,  0, 10},  // R4 polarity inverted
        '{0, 9, 20, 1, 10,  0,  0},  // R3 compare far above limit
        '{0, 9, 3, 13,  3,  3, 10},  // R5 comp polarity
        '{3, 2, 1,  7,  8,  8, 12},  // R4 R5 inverted main with comp
        '{0, 9, 3,  4,  0,  0,  0}   // R6 channel disabled, comp en set
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NCH-1:0]    pwm_out, pwm_n_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    multich_pwm_timer #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .pwm_n_out(pwm_n_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int ch, input int win, output int hm, output int hn);
        hm = 0; hn = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            hm += int'(pwm_out[ch]);
            hn += int'(pwm_n_out[ch]);
        end
    endtask

    task automatic period_of(output int per);
        logic prev;
        int   n;
        per = -1;
        @(negedge clk); prev = pwm_out[0];
        n = 0;
        while (!(prev == 1'b0 && pwm_out[0] == 1'b1) && n < 2000) begin
            prev = pwm_out[0]; @(negedge clk); n++;
        end
        n = 0;
        prev = pwm_out[0];
        do begin
            @(negedge clk); n++;
            if (prev == 1'b0 && pwm_out[0] == 1'b1) per = n;
            prev = pwm_out[0];
        end while (per < 0 && n < 2000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int hm, hn, per, win;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R12 reset state
        measure(0, 20, hm, hn);
        chk("R12 reset main", hm + int'(pwm_out != 0), 0);
        chk("R12 reset comp", hn + int'(pwm_n_out != 0), 0);

        // table walk on channel 0
        for (int v = 0; v < NV; v++) begin
            wr(0, 0);
            wr(1, VEC[v].psc);
            wr(2, VEC[v].lim);
            wr(4, VEC[v].cmp);
            wr(3, VEC[v].cfg);
            wr(0, 4'b1101);          // run, gate, update request (R11)
            win = (VEC[v].psc + 1) * (VEC[v].lim + 1);
            repeat (2 * win + 4) @(negedge clk);
            measure(0, win, hm, hn);
            chk($sformatf("R2 main high v%0d", v), hm, VEC[v].hm);
            chk($sformatf("R5 comp high v%0d", v), hn, VEC[v].hn);
            if (VEC[v].per != 0) begin
                period_of(per);
                chk($sformatf("R1 period v%0d", v), per, VEC[v].per);
            end
        end

        // R7 gate or run cleared
        wr(0, 0); wr(1, 0); wr(2, 9); wr(4, 3); wr(3, 5);
        wr(0, 4'b1100);
        measure(0, 25, hm, hn);
        chk("R7 run clear main", hm, 0);
        chk("R7 run clear comp", hn, 0);
        wr(0, 4'b1001);
        measure(0, 25, hm, hn);
        chk("R7 gate clear main", hm, 0);
        chk("R7 gate clear comp", hn, 0);

        // R11 two channels independent
        wr(4, 3); wr(5, 6); wr(3, 8'h11);
        wr(0, 4'b1101);
        repeat (24) @(negedge clk);
        measure(0, 10, hm, hn);
        chk("R11 ch0 high", hm, 3);
        measure(1, 10, hm, hn);
        chk("R11 ch1 high", hm, 6);

        // R8 / R10 preload behaviour
        wr(0, 0); wr(1, 0); wr(2, 199); wr(4, 100); wr(3, 1);
        wr(0, 4'b1111);
        repeat (10) @(negedge clk);
        chk("R8 baseline high", int'(pwm_out[0]), 1);
        wr(4, 0);
        repeat (3) @(negedge clk);
        chk("R8 preloaded write held", int'(pwm_out[0]), 1);
        wr(0, 4'b1111);
        repeat (3) @(negedge clk);
        chk("R10 update request loads", int'(pwm_out[0]), 0);
        wr(4, 100);
        repeat (3) @(negedge clk);
        chk("R8 held until wrap", int'(pwm_out[0]), 0);
        repeat (205) @(negedge clk);
        chk("R8 loaded at wrap", int'(pwm_out[0]), 1);

        // R9 preload off
        wr(0, 4'b0101);
        wr(4, 0);
        repeat (2) @(negedge clk);
        chk("R9 immediate write", int'(pwm_out[0]), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule